// File: doc/BRIEF.md
# Bit-Serial Accumulator Processor Sequencer

This block is the control core of a tiny accumulator machine whose datapath is a single bit wide. Each instruction word is 8 bits. The top three bits are the operation and the low five bits are a memory address. The block owns a 5-bit program counter, an instruction register, an 8-bit accumulator and a serial ALU. A phase state machine drives all of them. Every move of a data word between memory, accumulator and ALU is an 8-cycle serial burst, least significant bit first. A 32-word behavioural memory sits inside the block. It has a side port to load programs and a combinational port to inspect any word.

The state machine steps each instruction through fixed phases. FETCH takes 8 cycles and shifts the word at the program counter into the instruction register. INC takes 1 cycle and advances the program counter. OPND takes 8 cycles and shifts the addressed memory word into an operand buffer. ALU takes 8 cycles and streams the accumulator and the operand through the serial ALU. MEM takes 8 cycles and performs the store and the program-counter override. The transitions are:
- FETCH→INC after bit 7.
- INC→OPND, or INC→HALT when the operation is halt.
- OPND→ALU, ALU→MEM and MEM→FETCH, each after bit 7.
- HALT→HALT.

Only reset leaves HALT.

Top module: `bsq_cpu`

## Requirements
- R1: While reset is held, and on the first cycle after it, the program counter reads 0, the accumulator reads 0, the halted output is 0 and the phase output reads 0 (FETCH).
- R2: An instruction word carries the operation in bits 7..5 and the address in bits 4..0. The operation codes are 0 halt, 1 add, 2 load, 3 store, 4 skip-if-zero, 5 jump, and 6 or 7 no-op. The phase output codes are FETCH 0, INC 1, OPND 2, ALU 3, MEM 4, HALT 5.
- R3: Every instruction other than halt takes exactly 33 cycles: 8 in FETCH, 1 in INC, 8 in OPND, 8 in ALU and 8 in MEM. A halt reaches the HALT phase 9 cycles after its fetch begins.
- R4: Add sets the accumulator to the accumulator plus the addressed word, modulo 256. The carry out of bit 7 is dropped.
- R5: Load copies the addressed word into the accumulator.
- R6: Store writes the accumulator into the addressed word and leaves the accumulator unchanged.
- R7: Skip-if-zero with an accumulator of 0 advances the program counter one extra step, so the next instruction is not executed.
- R8: Skip-if-zero with a nonzero accumulator executes the next instruction normally.
- R9: Jump makes the operand address the next instruction address.
- R10: Halt raises the halted output. The program counter then reads the address after the halt. Program counter, accumulator and phase stay frozen until reset.
- R11: Operation codes 6 and 7 change neither the accumulator nor memory, and execution continues at the next address.
- R12: The program counter steps from 31 to 0 on increment.
- R13: A write on the load port replaces a whole memory word. The peek port shows any word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Program load write enable |
| ld_addr | input | 5 | Program load address |
| ld_data | input | 8 | Program load word |
| pk_addr | input | 5 | Memory inspect address |
| pk_data | output | 8 | Memory word at pk_addr |
| pc_o | output | 5 | Program counter |
| acc_o | output | 8 | Accumulator contents |
| phase_o | output | 3 | Current phase code |
| halted_o | output | 1 | High once a halt has executed |

## Verification
The bench builds the block with its default widths: a 5-bit address and an 8-bit word, so 32 memory words. At these widths a short program can run past the last address and wrap to 0. The add vectors cover carries through every bit position, including the dropped carry out of bit 7. Because the memory is small, every word can be cleared and loaded before each program. Counting cycles to halt pins down the 33-cycle instruction length exactly.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [2:0] {
        PH_FETCH = 3'd0,
        PH_INC   = 3'd1,
        PH_OPND  = 3'd2,
        PH_ALU   = 3'd3,
        PH_MEM   = 3'd4,
        PH_HALT  = 3'd5
    } phase_t;

    typedef enum logic [OPC_W-1:0] {
        OP_HLT  = 3'd0,
        OP_ADD  = 3'd1,
        OP_LDA  = 3'd2,
        OP_STA  = 3'd3,
        OP_SKP  = 3'd4,
        OP_JMP  = 3'd5,
        OP_NOP6 = 3'd6,
        OP_NOP7 = 3'd7
    } opcode_t;

    typedef enum logic [1:0] {
        SEL_ACC = 2'd0,
        SEL_MEM = 2'd1,
        SEL_SUM = 2'd2
    } alu_sel_t;

endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
    import bsq_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  opcode_t          opc,
    input  logic             zero,
    output phase_t           phase,
    output logic [CNT_W-1:0] bit_idx,
    output logic             first_bit,
    output logic             ir_shift,
    output logic             op_fill,
    output logic             op_rot,
    output logic             alu_en,
    output alu_sel_t         alu_sel,
    output logic             acc_shift,
    output logic             mem_we,
    output logic             use_opnd,
    output logic             pc_inc,
    output logic             pc_load,
    output logic             halted
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    phase_t           phase_nx;
    logic             last_bit;
    logic             serial_ph;

    assign last_bit  = (bit_idx == LAST_IDX);
    assign first_bit = (bit_idx == '0);
    assign serial_ph = (phase == PH_FETCH) || (phase == PH_OPND) ||
                       (phase == PH_ALU)   || (phase == PH_MEM);

    // state register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_FETCH;
            bit_idx <= '0;
        end else begin
            phase <= phase_nx;
            if (serial_ph && !last_bit)
                bit_idx <= bit_idx + 1'b1;
            else
                bit_idx <= '0;
        end
    end

    // next phase
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_FETCH: phase_nx = last_bit ? PH_INC : PH_FETCH;
            PH_INC:   phase_nx = (opc == OP_HLT) ? PH_HALT : PH_OPND;
            PH_OPND:  phase_nx = last_bit ? PH_ALU : PH_OPND;
            PH_ALU:   phase_nx = last_bit ? PH_MEM : PH_ALU;
            PH_MEM:   phase_nx = last_bit ? PH_FETCH : PH_MEM;
            PH_HALT:  phase_nx = PH_HALT;
            default:  phase_nx = PH_HALT;
        endcase
    end

    // phase outputs
    always_comb begin
        ir_shift  = 1'b0;
        op_fill   = 1'b0;
        op_rot    = 1'b0;
        alu_en    = 1'b0;
        alu_sel   = SEL_ACC;
        acc_shift = 1'b0;
        mem_we    = 1'b0;
        use_opnd  = 1'b1;
        pc_inc    = 1'b0;
        pc_load   = 1'b0;
        halted    = 1'b0;
        unique case (phase)
            PH_FETCH: begin
                ir_shift = 1'b1;
                use_opnd = 1'b0;
            end
            PH_INC: begin
                pc_inc = 1'b1;
            end
            PH_OPND: begin
                op_fill = 1'b1;
            end
            PH_ALU: begin
                op_rot    = 1'b1;
                alu_en    = 1'b1;
                acc_shift = 1'b1;
                if (opc == OP_ADD)
                    alu_sel = SEL_SUM;
                else if (opc == OP_LDA)
                    alu_sel = SEL_MEM;
                else
                    alu_sel = SEL_ACC;
            end
            PH_MEM: begin
                acc_shift = 1'b1;
                alu_sel   = SEL_ACC;
                mem_we    = (opc == OP_STA);
                pc_load   = first_bit && (opc == OP_JMP);
                pc_inc    = first_bit && (opc == OP_SKP) && zero;
            end
            PH_HALT: begin
                halted = 1'b1;
            end
            default: begin
                halted = 1'b1;
            end
        endcase
    end

    // R10
    // once halted, the sequencer never leaves the halt phase without reset
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HALT) |=> (phase == PH_HALT));

    // R3
    // the increment phase lasts exactly one cycle
    inc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INC) |=> (phase == PH_OPND || phase == PH_HALT));

    // R3
    // a serial phase only moves on after its last bit
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_ph && !last_bit) |=> $stable(phase));

endmodule

// File: rtl/bsq_alu.sv
module bsq_alu
    import bsq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     first_bit,
    input  alu_sel_t sel,
    input  logic     a_bit,
    input  logic     b_bit,
    output logic     res_bit,
    output logic     zero
);

    logic carry_q;
    logic nz_q;
    logic cin;
    logic sum_bit;
    logic nz_prev;

    assign cin     = first_bit ? 1'b0 : carry_q;
    assign sum_bit = a_bit ^ b_bit ^ cin;
    assign nz_prev = first_bit ? 1'b0 : nz_q;

    // carry and nonzero feedback loops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            nz_q    <= 1'b0;
        end else if (en) begin
            carry_q <= (a_bit & b_bit) | (cin & (a_bit ^ b_bit));
            nz_q    <= nz_prev | a_bit;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_SUM: res_bit = sum_bit;
            SEL_MEM: res_bit = b_bit;
            SEL_ACC: res_bit = a_bit;
            default: res_bit = a_bit;
        endcase
    end

    assign zero = ~nz_q;

    // R4
    // a burst always starts from a clear carry
    carry_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && first_bit && sel == SEL_SUM) |-> (res_bit == (a_bit ^ b_bit)));

endmodule

// File: rtl/bsq_regs.sv
module bsq_regs #(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_bit,
    input  logic              res_bit,
    input  logic              ir_shift,
    input  logic              op_fill,
    input  logic              op_rot,
    input  logic              acc_shift,
    input  logic              pc_inc,
    input  logic              pc_load,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ir,
    output logic [WORD_W-1:0] acc,
    output logic              op_lsb
);

    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    logic [WORD_W-1:0] opbuf;

    assign op_lsb = opbuf[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            ir    <= '0;
            acc   <= '0;
            opbuf <= '0;
        end else begin
            if (pc_load)
                pc <= ir[ADDR_W-1:0];
            else if (pc_inc)
                pc <= pc + PC_ONE;
            if (ir_shift)
                ir <= {rd_bit, ir[WORD_W-1:1]};
            if (op_fill)
                opbuf <= {rd_bit, opbuf[WORD_W-1:1]};
            else if (op_rot)
                opbuf <= {opbuf[0], opbuf[WORD_W-1:1]};
            if (acc_shift)
                acc <= {res_bit, acc[WORD_W-1:1]};
        end
    end

endmodule

// File: rtl/bsq_mem.sv
module bsq_mem #(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W),
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic              we,
    input  logic              wr_bit,
    output logic              rd_bit,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] pk_addr,
    output logic [WORD_W-1:0] pk_data
);

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we)
            store[ld_addr] <= ld_data;
        else if (we)
            store[addr][bit_idx] <= wr_bit;
    end

    assign rd_bit  = store[addr][bit_idx];
    assign pk_data = store[pk_addr];

endmodule

// File: rtl/bsq_cpu.sv
module bsq_cpu
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int WORD_W = OPC_W + ADDR_W,
    localparam int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] pk_addr,
    output logic [WORD_W-1:0] pk_data,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] acc_o,
    output logic [2:0]        phase_o,
    output logic              halted_o
);

    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    phase_t            phase;
    opcode_t           opc;
    alu_sel_t          alu_sel;
    logic [CNT_W-1:0]  bit_idx;
    logic              first_bit;
    logic              ir_shift, op_fill, op_rot, alu_en, acc_shift;
    logic              mem_we, use_opnd, pc_inc, pc_load, halted;
    logic              zero, res_bit, rd_bit, op_lsb;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] acc;
    logic [ADDR_W-1:0] mem_addr;

    assign opc      = opcode_t'(ir[WORD_W-1 -: OPC_W]);
    assign mem_addr = use_opnd ? ir[ADDR_W-1:0] : pc;

    bsq_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opc       (opc),
        .zero      (zero),
        .phase     (phase),
        .bit_idx   (bit_idx),
        .first_bit (first_bit),
        .ir_shift  (ir_shift),
        .op_fill   (op_fill),
        .op_rot    (op_rot),
        .alu_en    (alu_en),
        .alu_sel   (alu_sel),
        .acc_shift (acc_shift),
        .mem_we    (mem_we),
        .use_opnd  (use_opnd),
        .pc_inc    (pc_inc),
        .pc_load   (pc_load),
        .halted    (halted)
    );

    bsq_alu u_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (alu_en),
        .first_bit (first_bit),
        .sel       (alu_sel),
        .a_bit     (acc[0]),
        .b_bit     (op_lsb),
        .res_bit   (res_bit),
        .zero      (zero)
    );

    bsq_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_bit    (rd_bit),
        .res_bit   (res_bit),
        .ir_shift  (ir_shift),
        .op_fill   (op_fill),
        .op_rot    (op_rot),
        .acc_shift (acc_shift),
        .pc_inc    (pc_inc),
        .pc_load   (pc_load),
        .pc        (pc),
        .ir        (ir),
        .acc       (acc),
        .op_lsb    (op_lsb)
    );

    bsq_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk     (clk),
        .addr    (mem_addr),
        .bit_idx (bit_idx),
        .we      (mem_we),
        .wr_bit  (acc[0]),
        .rd_bit  (rd_bit),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .pk_addr (pk_addr),
        .pk_data (pk_data)
    );

    assign pc_o     = pc;
    assign acc_o    = acc;
    assign phase_o  = phase;
    assign halted_o = halted;

    // R10
    // a halted machine keeps its program counter and accumulator
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && $stable(acc)));

    // R12
    // the increment phase advances the program counter by one, modulo 32
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INC) |=> (pc == $past(pc) + PC_ONE));

    // R7
    // the zero flag seen by a skip matches the accumulator it streamed
    skp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MEM && first_bit && opc == OP_SKP) |-> (zero == (acc == '0)));

    // R3
    // the serial ALU only works during the ALU phase
    alu_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_en |-> (phase == PH_ALU));

endmodule

// File: tb/bsq_cpu_test.sv
module bsq_cpu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we = 1'b0;
    logic [4:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [4:0] pk_addr = '0;
    logic [7:0] pk_data;
    logic [4:0] pc_o;
    logic [7:0] acc_o;
    logic [2:0] phase_o;
    logic       halted_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    bsq_cpu uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_we    (ld_we),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .pk_addr  (pk_addr),
        .pk_data  (pk_data),
        .pc_o     (pc_o),
        .acc_o    (acc_o),
        .phase_o  (phase_o),
        .halted_o (halted_o)
    );

    // add vectors: {a, b, expected sum}
    localparam logic [23:0] VEC [6] = '{
        {8'h12, 8'h34, 8'h46},
        {8'hFF, 8'h01, 8'h00},
        {8'h80, 8'h80, 8'h00},
        {8'h7F, 8'h7F, 8'hFE},
        {8'h00, 8'h00, 8'h00},
        {8'hA5, 8'h5A, 8'hFF}
    };

    function automatic logic [7:0] ins(input int op, input int a);
        return {3'(op), 5'(a)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk);
        ld_we   = 1'b1;
        ld_addr = 5'(a);
        ld_data = d;
    endtask

    task automatic clear_mem();
        rst_n = 1'b0;
        for (int i = 0; i < 32; i++) poke(i, 8'h00);
    endtask

    task automatic run();
        @(negedge clk);
        ld_we = 1'b0;
        @(negedge clk);
        rst_n  = 1'b1;
        cycles = 0;
        while (!halted_o && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
        if (!halted_o) check("R10 timeout", 0, 1);
    endtask

    task automatic peek_check(input string tag, input int a, input logic [7:0] exp);
        pk_addr = 5'(a);
        #1;
        check(tag, pk_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [4:0] pc_snap;
        // R1 reset state
        clear_mem();
        @(negedge clk);
        ld_we = 1'b0;
        check("R1 pc", pc_o, 0);
        check("R1 acc", acc_o, 0);
        check("R1 halted", halted_o, 0);
        check("R1 phase", phase_o, 0);

        // R13 load and peek port
        poke(7, 8'h9C);
        @(negedge clk);
        ld_we = 1'b0;
        peek_check("R13 load/peek", 7, 8'h9C);

        // R4 R5 R6 R3: vector table walk, LDA 20; ADD 21; STA 22; HLT
        foreach (VEC[i]) begin
            clear_mem();
            poke(0, ins(2, 20));
            poke(1, ins(1, 21));
            poke(2, ins(3, 22));
            poke(20, VEC[i][23:16]);
            poke(21, VEC[i][15:8]);
            run();
            check("R4 add acc", acc_o, VEC[i][7:0]);
            peek_check("R6 store word", 22, VEC[i][7:0]);
            peek_check("R5 source kept", 20, VEC[i][23:16]);
            check("R10 halt pc", pc_o, 4);
            check("R3 cycles to halt", cycles, 33 * 3 + 9);
        end

        // R10 frozen after halt
        pc_snap = pc_o;
        repeat (50) @(negedge clk);
        check("R10 halted stays", halted_o, 1);
        check("R10 pc frozen", pc_o, pc_snap);
        check("R2 halt phase code", phase_o, 5);

        // R7 skip when zero
        clear_mem();
        poke(0, ins(4, 0));
        poke(1, ins(2, 20));
        poke(20, 8'h55);
        run();
        check("R7 skipped load", acc_o, 0);
        check("R7 pc", pc_o, 3);

        // R8 no skip when nonzero
        clear_mem();
        poke(0, ins(2, 20));
        poke(1, ins(4, 0));
        poke(2, ins(2, 21));
        poke(20, 8'h01);
        poke(21, 8'h77);
        run();
        check("R8 next executed", acc_o, 8'h77);
        check("R8 pc", pc_o, 4);

        // R9 jump
        clear_mem();
        poke(0, ins(5, 5));
        poke(1, ins(2, 20));
        poke(20, 8'h33);
        run();
        check("R9 jump acc", acc_o, 0);
        check("R9 jump pc", pc_o, 6);
        check("R3 jump timing", cycles, 33 + 9);

        // R12 wrap 31 -> 0
        clear_mem();
        poke(0, ins(4, 0));
        poke(1, ins(0, 0));
        poke(2, ins(5, 30));
        poke(30, ins(2, 20));
        poke(31, ins(1, 21));
        poke(20, 8'h10);
        poke(21, 8'h05);
        run();
        check("R12 wrap acc", acc_o, 8'h15);
        check("R12 wrap pc", pc_o, 2);

        // R11 codes 6 and 7 are no-ops
        clear_mem();
        poke(0, ins(2, 20));
        poke(1, ins(6, 21));
        poke(2, ins(7, 21));
        poke(20, 8'h6A);
        poke(21, 8'h0F);
        run();
        check("R11 acc kept", acc_o, 8'h6A);
        peek_check("R11 mem kept", 21, 8'h0F);
        check("R11 pc", pc_o, 4);

        // R1 reset restarts from address 0
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset after halt", halted_o, 0);
        check("R1 pc after reset", pc_o, 0);

        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule